// File: doc/BRIEF.md
# Serial Display-Memory Port

This block is the host side of a segment display controller. A host reaches it over three control lines and one data line: an active-low select, a write strobe, a read strobe, and a data line that is shown at the ports as a separate input, output and output enable. Behind the port is a 64-word store of 4-bit nibbles that holds the display image. A second, read-only port lets the display scan logic fetch any nibble at any time.

Each frame opens when select goes low. The first three bits written form the mode code. That code picks one of four transfers. Read streams nibbles out. Write streams nibbles in. Read-modify-write returns each nibble and then takes a replacement for it. A command transfer passes 9-bit words to a separate configuration block. In the nibble transfers the address advances by itself, so one address can be followed by any number of nibbles. The select and strobe lines are asynchronous to the block. They are resynchronized into a system clock that runs several times faster than the strobes, and their edges are found there.

Top module: `dispram_serial_port`

## Requirements
- R1: After reset, dio_oe and cfg_stb are 0 and every stored nibble reads 0 on the display port.
- R2: A frame that starts with mode code 101, followed by six address bits sent most significant first and four data bits sent least significant first (each bit captured at a rising write strobe), stores that nibble at that address.
- R3: When more nibbles follow in the same write frame, each goes to the next address, and address 63 is followed by address 0.
- R4: A frame that starts with code 110 and an address drives the stored bits onto dio_out, least significant first, one bit per falling read strobe. Later nibbles come from successive addresses, and the address wraps from 63 to 0.
- R5: In a 101 frame, a falling read strobe at a nibble boundary shifts the addressed nibble out. The next four written bits replace that same nibble, and the sequence then moves to the next address.
- R6: A frame with code 100 carries 9-bit words sent C8 first. Each completed word gives exactly one cfg_stb pulse with cfg_code[7:0] = C8..C1, and C0 is discarded. Further words may follow without a new code.
- R7: Select going high abandons a partial frame, so no partial nibble is stored and no partial command is strobed. The first three bits after select falls again are taken as a new mode code.
- R8: Any other mode code (000, 001, 010, 011, 111) makes the rest of the frame inert. Nothing is stored, cfg_stb stays 0 and dio_oe stays 0.
- R9: dio_oe is 1 only in the read part of a transfer. It is 0 during write and command transfers and falls after select goes high.
- R10: Strobes that arrive while select is high change no stored nibble and produce no cfg_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the strobe rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select, asynchronous |
| wr_n | input | 1 | Write strobe; bit captured on its rising edge |
| rd_n | input | 1 | Read strobe; bit driven after its falling edge |
| dio_in | input | 1 | Data line as seen by the block |
| dio_out | output | 1 | Data line value driven by the block |
| dio_oe | output | 1 | Drive enable for the data line |
| cfg_stb | output | 1 | One-cycle pulse per completed command word |
| cfg_code | output | 8 | Command bits C8..C1 that go with cfg_stb |
| disp_addr | input | 6 | Display-scan read address |
| disp_data | output | 4 | Nibble stored at disp_addr |

## Verification
If the bit counter or address register goes wrong inside the block, a nibble lands one place off or out of order. That shows on disp_data within the same frame, or in the very next read frame. If the mode decoder is wrong, a frame stores when it should be inert, or the wrong kind of transfer runs. If the select handling is wrong, a partial frame leaks through as a stored nibble or a cfg_stb pulse. These faults appear within one frame of the stimulus. A drive enable left on shows as dio_oe high during a write or command frame, or after select rises. It shows there about three system clocks after the strobe edge that should have released it.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
   localparam int ID_W = 3;
   localparam logic [ID_W-1:0] ID_READ  = 3'b110;
   localparam logic [ID_W-1:0] ID_WRITE = 3'b101;
   localparam logic [ID_W-1:0] ID_CMD   = 3'b100;

   typedef enum logic [2:0] {
      PH_ID,
      PH_ADDR,
      PH_WDATA,
      PH_RDATA,
      PH_CMD,
      PH_DROP
   } phase_t;
endpackage

// File: rtl/dsp_sync_cell.sv
module dsp_sync_cell #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= {STAGES{RST_VAL}};
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/dsp_nibble_ram.sv
module dsp_nibble_ram #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [ADDR_W-1:0] raddr_b,
   output logic [DATA_W-1:0] rdata_b
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/dsp_serial_fsm.sv
module dsp_serial_fsm
   import dsp_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 4,
   parameter int CMD_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_q,
   input  logic              wr_rise,
   input  logic              rd_fall,
   input  logic              rd_rise,
   input  logic              din_q,
   input  logic [DATA_W-1:0] rd_nib,
   output logic [ADDR_W-1:0] addr,
   output logic              ram_we,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              dout,
   output logic              oe,
   output logic              cfg_stb,
   output logic [CMD_W-2:0]  cfg_code,
   output phase_t            phase
);
   localparam int CNT_W  = $clog2(CMD_W + 1);
   localparam int DIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_ID = CNT_W'(ID_W - 1);
   localparam logic [CNT_W-1:0] LAST_A  = CNT_W'(ADDR_W - 1);
   localparam logic [CNT_W-1:0] LAST_D  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(CMD_W - 1);

   logic [CNT_W-1:0]  bcnt;
   logic [CMD_W-1:0]  sh;
   logic [CMD_W-1:0]  sh_nxt;
   logic [DATA_W-1:0] wnib;
   logic [DATA_W-1:0] wnib_nxt;
   logic [DIDX_W-1:0] bidx;
   logic [ID_W-1:0]   id_nxt;
   logic              rmw;

   assign bidx   = bcnt[DIDX_W-1:0];
   assign sh_nxt = {sh[CMD_W-2:0], din_q};
   assign id_nxt = sh_nxt[ID_W-1:0];

   always_comb begin
      wnib_nxt       = wnib;
      wnib_nxt[bidx] = din_q;
   end

   // the store happens on the strobe that completes a written nibble
   assign ram_we    = !cs_q && (phase == PH_WDATA) && wr_rise && (bcnt == LAST_D);
   assign ram_wdata = wnib_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_ID;
         bcnt     <= '0;
         sh       <= '0;
         wnib     <= '0;
         addr     <= '0;
         rmw      <= 1'b0;
         dout     <= 1'b0;
         oe       <= 1'b0;
         cfg_stb  <= 1'b0;
         cfg_code <= '0;
      end else if (cs_q) begin
         phase   <= PH_ID;
         bcnt    <= '0;
         sh      <= '0;
         rmw     <= 1'b0;
         oe      <= 1'b0;
         cfg_stb <= 1'b0;
      end else begin
         cfg_stb <= 1'b0;
         if (rd_rise && phase != PH_RDATA) oe <= 1'b0;
         case (phase)
            PH_ID: if (wr_rise) begin
               sh <= sh_nxt;
               if (bcnt == LAST_ID) begin
                  bcnt <= '0;
                  rmw  <= (id_nxt == ID_WRITE);
                  if (id_nxt == ID_READ || id_nxt == ID_WRITE) phase <= PH_ADDR;
                  else if (id_nxt == ID_CMD)                  phase <= PH_CMD;
                  else                                        phase <= PH_DROP;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            PH_ADDR: if (wr_rise) begin
               addr <= {addr[ADDR_W-2:0], din_q};
               if (bcnt == LAST_A) begin
                  bcnt  <= '0;
                  phase <= rmw ? PH_WDATA : PH_RDATA;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            PH_WDATA: begin
               if (wr_rise) begin
                  wnib <= wnib_nxt;
                  if (bcnt == LAST_D) begin
                     bcnt <= '0;
                     addr <= addr + 1'b1;
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end else if (rd_fall && bcnt == '0) begin
                  dout  <= rd_nib[0];
                  oe    <= 1'b1;
                  bcnt  <= 1;
                  phase <= PH_RDATA;
               end
            end
            PH_RDATA: if (rd_fall) begin
               dout <= rd_nib[bidx];
               oe   <= 1'b1;
               if (bcnt == LAST_D) begin
                  bcnt <= '0;
                  if (rmw) phase <= PH_WDATA;
                  else     addr  <= addr + 1'b1;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            PH_CMD: if (wr_rise) begin
               sh <= sh_nxt;
               if (bcnt == LAST_C) begin
                  bcnt     <= '0;
                  cfg_stb  <= 1'b1;
                  cfg_code <= sh_nxt[CMD_W-1:1];
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dispram_serial_port.sv
module dispram_serial_port
   import dsp_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 4,
   parameter int CMD_W       = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic              dio_in,
   output logic              dio_out,
   output logic              dio_oe,
   output logic              cfg_stb,
   output logic [CMD_W-2:0]  cfg_code,
   input  logic [ADDR_W-1:0] disp_addr,
   output logic [DATA_W-1:0] disp_data
);
   localparam int NSIG = 4;

   initial begin
      assert (ADDR_W >= 2)           else $error("ADDR_W must be at least 2");
      assert (DATA_W >= 1)           else $error("DATA_W must be at least 1");
      assert (CMD_W >= ADDR_W)       else $error("CMD_W must cover the address length");
      assert (CMD_W >= DATA_W)       else $error("CMD_W must cover the nibble length");
      assert (SYNC_STAGES >= 2)      else $error("SYNC_STAGES must be at least 2");
   end

   logic [NSIG-1:0] raw;
   logic [NSIG-1:0] synced;

   assign raw = {dio_in, rd_n, wr_n, cs_n};

   for (genvar g = 0; g < NSIG; g++) begin : g_sync
      dsp_sync_cell #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cell (
         .clk  (clk),
         .rst_n(rst_n),
         .d    (raw[g]),
         .q    (synced[g])
      );
   end

   logic cs_q, wr_q, rd_q, din_q;
   logic wr_p, rd_p;
   logic wr_rise, rd_fall, rd_rise;

   assign cs_q  = synced[0];
   assign wr_q  = synced[1];
   assign rd_q  = synced[2];
   assign din_q = synced[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_p <= 1'b1;
         rd_p <= 1'b1;
      end else begin
         wr_p <= wr_q;
         rd_p <= rd_q;
      end
   end

   assign wr_rise = wr_q & ~wr_p;
   assign rd_fall = ~rd_q & rd_p;
   assign rd_rise = rd_q & ~rd_p;

   logic [ADDR_W-1:0] addr;
   logic              ram_we;
   logic [DATA_W-1:0] ram_wdata;
   logic [DATA_W-1:0] rd_nib;
   phase_t            phase;
   logic              ph_cmd, ph_drop;

   dsp_serial_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_q     (cs_q),
      .wr_rise  (wr_rise),
      .rd_fall  (rd_fall),
      .rd_rise  (rd_rise),
      .din_q    (din_q),
      .rd_nib   (rd_nib),
      .addr     (addr),
      .ram_we   (ram_we),
      .ram_wdata(ram_wdata),
      .dout     (dio_out),
      .oe       (dio_oe),
      .cfg_stb  (cfg_stb),
      .cfg_code (cfg_code),
      .phase    (phase)
   );

   dsp_nibble_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ram_we),
      .waddr  (addr),
      .wdata  (ram_wdata),
      .raddr_a(addr),
      .rdata_a(rd_nib),
      .raddr_b(disp_addr),
      .rdata_b(disp_data)
   );

   assign ph_cmd  = (phase == PH_CMD);
   assign ph_drop = (phase == PH_DROP);
endmodule

// File: rtl/dispram_serial_port_chk.sv
module dispram_serial_port_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_q,
   input logic dio_oe,
   input logic cfg_stb,
   input logic ram_we,
   input logic ph_cmd,
   input logic ph_drop
);
   // R6: a command word yields a single-cycle strobe
   a_r6_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_stb |=> !cfg_stb);

   // R9: select high releases the data line on the next cycle
   a_r9_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |=> !dio_oe);

   // R9: command transfers never drive the data line
   a_r9_oe_cmd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ph_cmd |-> !dio_oe);

   // R8: an unrecognised mode leaves store, strobe and drive untouched
   a_r8_drop_inert: assert property (@(posedge clk) disable iff (!rst_n)
      ph_drop |-> (!ram_we && !cfg_stb && !dio_oe));

   // R7: select high returns the sequencer to mode-code collection
   a_r7_cs_restart: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |=> (!ph_cmd && !ph_drop));

   // R10: no store while select is high
   a_r10_no_store_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |-> !ram_we);
endmodule

bind dispram_serial_port dispram_serial_port_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs_q   (cs_q),
   .dio_oe (dio_oe),
   .cfg_stb(cfg_stb),
   .ram_we (ram_we),
   .ph_cmd (ph_cmd),
   .ph_drop(ph_drop)
);

// File: tb/dispram_serial_port_bench.sv
module dispram_serial_port_bench;
   localparam int CLK_PER = 10;
   localparam int HALF    = 8;
   localparam int NVEC    = 6;
   // {address[5:0], nibble[3:0]}
   localparam logic [9:0] VEC [NVEC] = '{10'h005, 10'h01A, 10'h3FF, 10'h203, 10'h11C, 10'h059};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, dio_in = 1'b1;
   logic       dio_out, dio_oe, cfg_stb;
   logic [7:0] cfg_code;
   logic [5:0] disp_addr = '0;
   logic [3:0] disp_data;

   int total = 0, bad = 0;
   int stb_cnt = 0;
   logic [7:0] last_code = '0;
   logic [3:0] exp_mem [64];
   logic       oe_seen;

   always #(CLK_PER/2) clk = ~clk;

   dispram_serial_port u_dispram_serial_port (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe),
      .cfg_stb(cfg_stb), .cfg_code(cfg_code),
      .disp_addr(disp_addr), .disp_data(disp_data)
   );

   always @(negedge clk) if (cfg_stb) begin
      stb_cnt++;
      last_code = cfg_code;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_bit(input logic b);
      dio_in = b; wr_n = 1'b0; wait_n(HALF);
      wr_n = 1'b1; wait_n(HALF);
   endtask

   task automatic rd_bit(output logic b);
      rd_n = 1'b0; wait_n(HALF - 2);
      b = dio_out; oe_seen = dio_oe;
      wait_n(2);
      rd_n = 1'b1; wait_n(HALF);
   endtask

   task automatic frame_on();  cs_n = 1'b0; wait_n(HALF); endtask
   task automatic frame_off(); cs_n = 1'b1; wait_n(HALF); endtask

   task automatic send(input logic [15:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) wr_bit(v[i]);
   endtask

   task automatic send_nib(input logic [3:0] d);
      for (int i = 0; i < 4; i++) wr_bit(d[i]);
   endtask

   task automatic get_nib(output logic [3:0] d);
      logic b;
      for (int i = 0; i < 4; i++) begin
         rd_bit(b);
         d[i] = b;
      end
   endtask

   task automatic look(input logic [5:0] a, output logic [3:0] d);
      disp_addr = a; wait_n(1);
      d = disp_data;
   endtask

   initial begin
      logic [3:0] got;
      for (int i = 0; i < 64; i++) exp_mem[i] = '0;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(3);

      // R1: reset state
      chk("R1 oe", 32'(dio_oe), 0);
      chk("R1 stb", 32'(cfg_stb), 0);
      look(6'd0, got);  chk("R1 mem0", 32'(got), 0);
      look(6'd63, got); chk("R1 mem63", 32'(got), 0);

      // R2 / R4: table of single-nibble writes, each read back serially
      for (int v = 0; v < NVEC; v++) begin
         frame_on(); send(16'b101, 3); send(16'(VEC[v][9:4]), 6); send_nib(VEC[v][3:0]);
         chk("R9 oe in write", 32'(dio_oe), 0);
         frame_off();
         exp_mem[VEC[v][9:4]] = VEC[v][3:0];
         look(VEC[v][9:4], got); chk("R2 write", 32'(got), 32'(VEC[v][3:0]));
         frame_on(); send(16'b110, 3); send(16'(VEC[v][9:4]), 6); get_nib(got);
         chk("R9 oe in read", 32'(oe_seen), 1);
         frame_off();
         chk("R4 read", 32'(got), 32'(VEC[v][3:0]));
         chk("R9 oe after cs", 32'(dio_oe), 0);
      end

      // R3: successive write across the top address
      frame_on(); send(16'b101, 3); send(16'd62, 6);
      send_nib(4'h1); send_nib(4'h2); send_nib(4'h3);
      frame_off();
      exp_mem[62] = 4'h1; exp_mem[63] = 4'h2; exp_mem[0] = 4'h3;
      look(6'd62, got); chk("R3 addr62", 32'(got), 1);
      look(6'd63, got); chk("R3 addr63", 32'(got), 2);
      look(6'd0, got);  chk("R3 wrap0", 32'(got), 3);

      // R4: successive read across the top address
      frame_on(); send(16'b110, 3); send(16'd63, 6);
      get_nib(got); chk("R4 seq63", 32'(got), 32'(exp_mem[63]));
      get_nib(got); chk("R4 seq wrap0", 32'(got), 32'(exp_mem[0]));
      get_nib(got); chk("R4 seq1", 32'(got), 32'(exp_mem[1]));
      frame_off();

      // R5: read-modify-write over two addresses
      exp_mem[10] = 4'h4; exp_mem[11] = 4'hB;
      frame_on(); send(16'b101, 3); send(16'd10, 6); send_nib(4'h4); send_nib(4'hB); frame_off();
      frame_on(); send(16'b101, 3); send(16'd10, 6);
      get_nib(got); chk("R5 rmw read10", 32'(got), 4);
      send_nib(4'h6);
      get_nib(got); chk("R5 rmw read11", 32'(got), 32'hB);
      send_nib(4'h7);
      frame_off();
      look(6'd10, got); chk("R5 rmw wrote10", 32'(got), 6);
      look(6'd11, got); chk("R5 rmw wrote11", 32'(got), 7);
      exp_mem[10] = 4'h6; exp_mem[11] = 4'h7;

      // R6: two command words behind one mode code
      frame_on(); send(16'b100, 3);
      send(16'b0_0000_0011, 9);
      chk("R6 stb count1", 32'(stb_cnt), 1);
      chk("R6 code1", 32'(last_code), 32'h01);
      send(16'b1_0100_1011, 9);
      chk("R6 stb count2", 32'(stb_cnt), 2);
      chk("R6 code2", 32'(last_code), 32'hA5);
      chk("R9 oe in cmd", 32'(dio_oe), 0);
      frame_off();

      // R7: abandoned write and abandoned command
      frame_on(); send(16'b101, 3); send(16'd20, 6); wr_bit(1'b1); wr_bit(1'b1); frame_off();
      look(6'd20, got); chk("R7 partial nibble dropped", 32'(got), 0);
      frame_on(); send(16'b100, 3); send(16'b11111, 5); frame_off();
      frame_on(); send(16'b101, 3); send(16'd21, 6); send_nib(4'hE); frame_off();
      exp_mem[21] = 4'hE;
      chk("R7 no partial cmd", 32'(stb_cnt), 2);
      look(6'd21, got); chk("R7 fresh code", 32'(got), 32'hE);
      look(6'd20, got); chk("R7 addr20 untouched", 32'(got), 0);

      // R8: unrecognised mode code
      frame_on(); send(16'b111, 3); send(16'd40, 6); send_nib(4'hF); send(16'h1FF, 9);
      get_nib(got);
      chk("R8 oe stays off", 32'(oe_seen), 0);
      frame_off();
      look(6'd40, got); chk("R8 no store", 32'(got), 0);
      chk("R8 no stb", 32'(stb_cnt), 2);
      frame_on(); send(16'b011, 3); send(16'd0, 6); send_nib(4'h9); frame_off();
      look(6'd0, got); chk("R8 code011 inert", 32'(got), 32'(exp_mem[0]));

      // R10: strobes with select high
      send(16'b101, 3); send(16'd5, 6); send_nib(4'h0);
      send(16'b100, 3); send(16'h1FF, 9);
      look(6'd5, got); chk("R10 mem unchanged", 32'(got), 32'(exp_mem[5]));
      chk("R10 no stb", 32'(stb_cnt), 2);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PER * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule